// File: doc/BRIEF.md
# Parity-guarded region memory controller

This block is the word-addressed memory behind a 26-bit fixed-point processor with a 15-bit address bus. Every request is steered by its address into one of three regions: a freely writable variable memory starting at word 0, a program memory starting at word 0x1000 that refuses writes, and a small vector PROM starting at 0x4000 that holds one handler address per interrupt level. Any address outside these three regions is treated as unmapped.

Each word is kept with two odd-parity bits, one for each 13-bit half, so a stored location is 28 bits wide. On a read both halves are checked. The combined error output goes high for one cycle in any of three cases: a parity failure, a write aimed at a protected region, or an access to an unmapped address. That output is meant to drive the processor's level-2 (parity / write error) interrupt. A build-time parameter can remove the parity storage and checking altogether.

The request side is a plain synchronous port. The block accepts one request in every cycle in which `req_valid` is high and has no ready signal, so it never applies back-pressure. A read answers exactly one cycle later, and the consumer cannot stall that answer. Writes produce no response beat.

Top module: `region_mem`

## Requirements
- R1: A read of variable memory (word addresses 0 to VM_WORDS-1, default 1024) returns the word last written there. `rsp_valid` is high in the cycle after the request, and the data is presented in that same cycle. `err` and `par_err` stay low.
- R2: A read of program memory (0x1000 to 0x1000+PM_WORDS-1, default up to 0x13FF) returns the image word {a[12:0] XOR 0x1555, NOT a[12:0]}. Here a is the request address, the first term fills bits 25:13 and the second fills bits 12:0. No error is flagged.
- R3: A write to program memory or to the vector PROM changes nothing. In the following cycle `err` is high for one cycle and `rsp_valid` stays low. Any write, legal or not, produces no `rsp_valid`.
- R4: In the vector PROM (0x4000 to 0x4000+VEC_WORDS-1, default 16 words), address 0x4000+2L returns 0x1000+32L for level L. Every odd address in the region returns 0.
- R5: An access to an unmapped address flags `err` in the following cycle. A read of such an address also raises `rsp_valid` with data 0. A write to such an address changes no variable-memory word; for example, a write to 0x0400 leaves word 0 as it was.
- R6: Stored parity bit 1 gives odd parity over data bits 25:13, and parity bit 0 gives odd parity over bits 12:0. The input `wr_bad_par[1]` inverts the upper parity bit and `wr_bad_par[0]` inverts the lower one on a variable-memory write. Reading back a word stored with either bit inverted returns the stored data with `par_err` and `err` both high. Whenever `par_err` is high, `err` is high too.
- R7: With PARITY_EN = 0, `par_err` never goes high. A word written with inverted parity then reads back with `err` low.
- R8: While reset is held, and in every cycle after a cycle with no request, `rsp_valid`, `err` and `par_err` are low.
- R9: Requests may arrive in every cycle with reads and writes mixed. Responses come out in request order, and a read issued right after a write to the same address returns the new data.
- R10: The edges of each region are exact. Addresses VM_WORDS-1 and 0x1000+PM_WORDS-1 are mapped, while VM_WORDS and 0x1000+PM_WORDS are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 26 | Write data |
| wr_bad_par | input | 2 | Invert stored parity bits (bit 1 upper, bit 0 lower) on a write |
| rsp_valid | output | 1 | Read data is presented this cycle |
| rsp_rdata | output | 26 | Read data, 0 when no read response |
| err | output | 1 | One-cycle error pulse: parity, protected write or unmapped access |
| par_err | output | 1 | Parity failure on the word presented this cycle |

## Verification
The assertions assume that `req_write`, `req_addr` and `wr_bad_par` are known whenever `req_valid` is high. They also assume that no read reaches a variable-memory word that has never been written, because such a word holds undefined data and parity. The stimulus reads only words it has written earlier. It drives every input at the falling edge and raises `wr_bad_par` only together with a write to variable memory. The second instance with parity disabled receives exactly the same stream.

// File: rtl/region_mem_pkg.sv
package region_mem_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_VM   = 2'd1,
    RGN_PM   = 2'd2,
    RGN_VEC  = 2'd3
  } region_e;
endpackage

// File: rtl/region_mem_decode.sv
module region_mem_decode
  import region_mem_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int VM_WORDS  = 1024,
  parameter int PM_BASE   = 'h1000,
  parameter int PM_WORDS  = 1024,
  parameter int VEC_BASE  = 'h4000,
  parameter int VEC_WORDS = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-1:0] offset
);
  logic hit_vm, hit_pm, hit_vec;
  int   a_int;

  always_comb begin
    a_int   = int'(addr);
    hit_vm  = (a_int < VM_WORDS);
    hit_pm  = (a_int >= PM_BASE) && (a_int < PM_BASE + PM_WORDS);
    hit_vec = (a_int >= VEC_BASE) && (a_int < VEC_BASE + VEC_WORDS);
    region  = RGN_NONE;
    offset  = '0;
    if (hit_vm) begin
      region = RGN_VM;
      offset = addr;
    end else if (hit_pm) begin
      region = RGN_PM;
      offset = addr - ADDR_W'(PM_BASE);
    end else if (hit_vec) begin
      region = RGN_VEC;
      offset = addr - ADDR_W'(VEC_BASE);
    end
  end

  // R10: the three windows never overlap, so at most one can claim an address
  always_comb begin
    if (!$isunknown(addr))
      assert_regions_disjoint_R10: assert ($onehot0({hit_vm, hit_pm, hit_vec}));
  end
endmodule

// File: rtl/region_mem_parity.sv
module region_mem_par_gen #(
  parameter int DATA_W = 26
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        flip,
  output logic [1:0]        par
);
  localparam int LO_W = DATA_W / 2;
  always_comb begin
    par[1] = ~(^data[DATA_W-1:LO_W]) ^ flip[1];
    par[0] = ~(^data[LO_W-1:0])      ^ flip[0];
  end
endmodule

module region_mem_par_chk #(
  parameter int DATA_W = 26
) (
  input  logic [DATA_W+1:0] word,
  output logic              bad
);
  localparam int LO_W = DATA_W / 2;
  logic ok_hi, ok_lo;
  always_comb begin
    ok_hi = ^{word[DATA_W+1], word[DATA_W-1:LO_W]};
    ok_lo = ^{word[DATA_W],   word[LO_W-1:0]};
    bad   = ~(ok_hi & ok_lo);
  end
endmodule

// File: rtl/region_mem_vm_array.sv
module region_mem_vm_array #(
  parameter int WIDTH = 28,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/region_mem_rom_image.sv
module region_mem_rom_image
  import region_mem_pkg::*;
#(
  parameter int DATA_W       = 26,
  parameter int ADDR_W       = 15,
  parameter int PM_BASE      = 'h1000,
  parameter int HANDLER_SPAN = 32,
  localparam int LO_W        = DATA_W / 2,
  localparam int HI_W        = DATA_W - LO_W
) (
  input  region_e           region,
  input  logic [LO_W-1:0]   addr_lo,
  input  logic [ADDR_W-1:0] offset,
  output logic [DATA_W-1:0] word
);
  localparam logic [HI_W-1:0] PM_MIX = HI_W'(32'h5555_5555);

  logic [DATA_W-1:0] pm_w, vec_w;

  always_comb begin
    pm_w  = {HI_W'(addr_lo) ^ PM_MIX, ~addr_lo};
    vec_w = DATA_W'(PM_BASE) + DATA_W'(HANDLER_SPAN) * DATA_W'(offset[ADDR_W-1:1]);
    if (offset[0]) vec_w = '0;
    unique case (region)
      RGN_PM:  word = pm_w;
      RGN_VEC: word = vec_w;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/region_mem.sv
module region_mem
  import region_mem_pkg::*;
#(
  parameter int DATA_W       = 26,
  parameter int ADDR_W       = 15,
  parameter int VM_WORDS     = 1024,
  parameter int PM_BASE      = 'h1000,
  parameter int PM_WORDS     = 1024,
  parameter int VEC_BASE     = 'h4000,
  parameter int VEC_WORDS    = 16,
  parameter int HANDLER_SPAN = 32,
  parameter bit PARITY_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        wr_bad_par,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err,
  output logic              par_err
);
  localparam int VM_AW = $clog2(VM_WORDS);
  localparam int LO_W  = DATA_W / 2;

  region_e           req_rgn;
  logic [ADDR_W-1:0] req_ofs;
  logic [DATA_W-1:0] rom_word;
  logic              vm_we, vm_re;

  logic              rsp_valid_q, dec_err_q;
  region_e           src_q;
  logic [DATA_W-1:0] sel_data;
  logic              chk_bad;

  region_mem_decode #(
    .ADDR_W(ADDR_W), .VM_WORDS(VM_WORDS), .PM_BASE(PM_BASE),
    .PM_WORDS(PM_WORDS), .VEC_BASE(VEC_BASE), .VEC_WORDS(VEC_WORDS)
  ) u_decode (
    .addr(req_addr), .region(req_rgn), .offset(req_ofs)
  );

  region_mem_rom_image #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PM_BASE(PM_BASE), .HANDLER_SPAN(HANDLER_SPAN)
  ) u_rom (
    .region(req_rgn), .addr_lo(req_addr[LO_W-1:0]), .offset(req_ofs), .word(rom_word)
  );

  assign vm_we = req_valid &  req_write & (req_rgn == RGN_VM);
  assign vm_re = req_valid & ~req_write & (req_rgn == RGN_VM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      dec_err_q   <= 1'b0;
      src_q       <= RGN_NONE;
    end else begin
      rsp_valid_q <= req_valid & ~req_write;
      dec_err_q   <= req_valid & ((req_rgn == RGN_NONE) | (req_write & (req_rgn != RGN_VM)));
      src_q       <= req_valid ? req_rgn : RGN_NONE;
    end
  end

  generate
    if (PARITY_EN) begin : g_par
      logic [1:0]        wr_par, rom_par;
      logic [DATA_W+1:0] vm_rd, rom_q, sel_word;
      logic              chk_raw;

      region_mem_par_gen #(.DATA_W(DATA_W)) u_gen_wr (
        .data(req_wdata), .flip(wr_bad_par), .par(wr_par)
      );
      region_mem_par_gen #(.DATA_W(DATA_W)) u_gen_rom (
        .data(rom_word), .flip(2'b00), .par(rom_par)
      );
      region_mem_vm_array #(.WIDTH(DATA_W+2), .DEPTH(VM_WORDS)) u_vm (
        .clk(clk), .we(vm_we), .waddr(req_ofs[VM_AW-1:0]), .wdata({wr_par, req_wdata}),
        .re(vm_re), .raddr(req_ofs[VM_AW-1:0]), .rdata(vm_rd)
      );

      always_ff @(posedge clk) rom_q <= {rom_par, rom_word};

      always_comb begin
        unique case (src_q)
          RGN_VM:          sel_word = vm_rd;
          RGN_PM, RGN_VEC: sel_word = rom_q;
          default:         sel_word = '0;
        endcase
      end

      region_mem_par_chk #(.DATA_W(DATA_W)) u_chk (.word(sel_word), .bad(chk_raw));

      assign sel_data = sel_word[DATA_W-1:0];
      assign chk_bad  = chk_raw & rsp_valid_q & (src_q != RGN_NONE);
    end else begin : g_nopar
      logic [DATA_W-1:0] vm_rd, rom_q;

      region_mem_vm_array #(.WIDTH(DATA_W), .DEPTH(VM_WORDS)) u_vm (
        .clk(clk), .we(vm_we), .waddr(req_ofs[VM_AW-1:0]), .wdata(req_wdata),
        .re(vm_re), .raddr(req_ofs[VM_AW-1:0]), .rdata(vm_rd)
      );

      always_ff @(posedge clk) rom_q <= rom_word;

      always_comb begin
        unique case (src_q)
          RGN_VM:          sel_data = vm_rd;
          RGN_PM, RGN_VEC: sel_data = rom_q;
          default:         sel_data = '0;
        endcase
      end

      assign chk_bad = 1'b0;
    end
  endgenerate

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = sel_data & {DATA_W{rsp_valid_q}};
  assign par_err   = chk_bad;
  assign err       = dec_err_q | chk_bad;

  assert_read_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);

  assert_write_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> !rsp_valid);

  assert_prot_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && (req_rgn == RGN_PM || req_rgn == RGN_VEC) |=> err);

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && (req_rgn == RGN_NONE) |=> (rsp_rdata == '0) && err);

  assert_par_in_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> err);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !err && !par_err);
endmodule

// File: tb/region_mem_tb.sv
module region_mem_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [25:0] req_wdata = '0;
  logic [1:0]  wr_bad_par = '0;
  logic        rsp_valid, err, par_err;
  logic [25:0] rsp_rdata;
  logic        np_valid, np_err, np_par_err;
  logic [25:0] np_rdata;

  always #5 clk = ~clk;

  region_mem u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_bad_par(wr_bad_par),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err(err), .par_err(par_err)
  );

  region_mem #(.PARITY_EN(1'b0)) u_dut_np (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_bad_par(wr_bad_par),
    .rsp_valid(np_valid), .rsp_rdata(np_rdata), .err(np_err), .par_err(np_par_err)
  );

  typedef struct {
    logic        v;
    logic [25:0] d;
    logic        e;
    logic        p;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;
  logic [25:0] vm_d [1024];
  logic        vm_b [1024];

  function automatic logic [25:0] pm_img(input logic [14:0] a);
    return {a[12:0] ^ 13'h1555, ~a[12:0]};
  endfunction

  function automatic logic [25:0] vec_img(input logic [14:0] a);
    logic [14:0] off;
    off = a - 15'h4000;
    if (off[0]) return '0;
    return 26'(32'h1000 + 32 * int'(off >> 1));
  endfunction

  // region: 0 none, 1 vm, 2 pm, 3 vec
  function automatic int rgn(input logic [14:0] a);
    if (a < 15'h0400) return 1;
    if (a >= 15'h1000 && a < 15'h1400) return 2;
    if (a >= 15'h4000 && a < 15'h4010) return 3;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic v, input logic [25:0] d, input logic e, input logic p, input string tag);
    exp_t x;
    x.v = v; x.d = d; x.e = e; x.p = p; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; wr_bad_par = 2'b00;
    push(1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; wr_bad_par = 2'b00;
    case (rgn(a))
      1: push(1'b1, vm_d[a[9:0]], vm_b[a[9:0]], vm_b[a[9:0]], tag);
      2: push(1'b1, pm_img(a), 1'b0, 1'b0, tag);
      3: push(1'b1, vec_img(a), 1'b0, 1'b0, tag);
      default: push(1'b1, '0, 1'b1, 1'b0, tag);
    endcase
  endtask

  task automatic wr(input logic [14:0] a, input logic [25:0] d, input logic [1:0] bad, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; wr_bad_par = bad;
    if (rgn(a) == 1) begin
      vm_d[a[9:0]] = d;
      vm_b[a[9:0]] = |bad;
      push(1'b0, '0, 1'b0, 1'b0, tag);
    end else begin
      push(1'b0, '0, 1'b1, 1'b0, tag);
    end
  endtask

  // monitor: each expectation pushed at a falling edge is due right after the next rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(x.tag, "rsp_valid", 32'(rsp_valid), 32'(x.v));
      check(x.tag, "err", 32'(err), 32'(x.e));
      check(x.tag, "par_err", 32'(par_err), 32'(x.p));
      if (x.v) check(x.tag, "rsp_rdata", 32'(rsp_rdata), 32'(x.d));
      // R7: parity-less instance sees the same stream without parity errors
      check({x.tag, "/R7"}, "np err", 32'(np_err), 32'(x.e & ~x.p));
      check({x.tag, "/R7"}, "np par_err", 32'(np_par_err), 32'h0);
      if (x.v) check({x.tag, "/R7"}, "np rdata", 32'(np_rdata), 32'(x.d));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R8", "reset rsp_valid", 32'(rsp_valid), 32'h0);
    check("R8", "reset err", 32'(err), 32'h0);
    check("R8", "reset par_err", 32'(par_err), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R8"); idle("R8");

    // R1 / R10: variable memory write and read back, including last word
    wr(15'h0000, 26'h2AAAAAA, 2'b00, "R1");
    wr(15'h0005, 26'h1234567, 2'b00, "R1");
    wr(15'h03FF, 26'h3FFFFFF, 2'b00, "R10");
    rd(15'h0000, "R1");
    rd(15'h0005, "R1");
    rd(15'h03FF, "R10");
    idle("R8");

    // R2 / R10: program memory image and its edges
    rd(15'h1000, "R2");
    rd(15'h1234, "R2");
    rd(15'h13FF, "R10");
    rd(15'h1400, "R10");
    rd(15'h0400, "R10");

    // R3: protected writes are rejected
    wr(15'h1010, 26'h0000001, 2'b00, "R3");
    idle("R3");
    rd(15'h1010, "R3");
    wr(15'h4002, 26'h0ABCDEF, 2'b00, "R3");
    rd(15'h4002, "R3");

    // R4: vector PROM
    rd(15'h4000, "R4");
    rd(15'h4004, "R4");
    rd(15'h400A, "R4");
    rd(15'h4003, "R4");
    rd(15'h400F, "R4");

    // R5: unmapped accesses
    rd(15'h2000, "R5");
    rd(15'h7FFF, "R5");
    wr(15'h0400, 26'h1111111, 2'b00, "R5");
    rd(15'h0000, "R5");
    wr(15'h4010, 26'h1111111, 2'b00, "R5");
    idle("R5");

    // R6: inverted parity on each half and on both
    wr(15'h0007, 26'h2000001, 2'b10, "R6");
    wr(15'h0008, 26'h0001FFF, 2'b01, "R6");
    wr(15'h0009, 26'h0000000, 2'b11, "R6");
    rd(15'h0007, "R6");
    rd(15'h0008, "R6");
    rd(15'h0009, "R6");
    wr(15'h0008, 26'h0001FFF, 2'b00, "R6");
    rd(15'h0008, "R6");

    // R9: back-to-back mixed traffic, read right after write
    for (int i = 0; i < 24; i++) begin
      logic [14:0] a;
      logic [25:0] d;
      a = 15'(32 + i * 37);
      d = 26'(32'h0155_5555 ^ (i * 32'h0011_3579));
      wr(a, d, 2'b00, "R9");
      rd(a, "R9");
      if (i % 3 == 0) rd(15'h1000 + 15'(i), "R9");
    end
    for (int i = 0; i < 24; i++) rd(15'(32 + i * 37), "R9");
    idle("R8"); idle("R8");

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule